// File: doc/BRIEF.md
# Addressed Serial Register Slave

This block is the device side of a shared serial programming bus. Line-level pulse decoding happens upstream, so the block sees only recovered events. These are a command code qualified by a valid strobe, data-bit strobes that carry one bit each, and prompt strobes that ask for one output bit. The host first runs an address phase with a 4-bit identifier. The device joins later transfers only when that identifier equals its own ID. It then either loads a 16-bit data register or streams that register back one bit per prompt.

The command codes are end-of-sequence `2'b00`, address `2'b01`, write `2'b10` and read `2'b11`. Address and data bits travel least significant bit first. Over-long bursts keep their most recent bits. The data register changes only when an end command closes a write that carried enough bits. The register value drives whatever function the device controls, and the serial output bit goes back to the host.

Top module: `addr_serial_slave`

## Requirements
- R1: A synchronous active-high reset clears the selection, the phase, all counters, the data register (`reg_q` = 0) and the serial output (`sdo` = 0).
- R2: Bits received after an address command (code `2'b01`) are taken LSB first, and an end command (code `2'b00`) resolves them. The device is selected when the last 4 bits received equal `DEV_ID`. It is deselected when they differ or when fewer than 4 bits arrived.
- R3: While the device is deselected, a write sequence leaves `reg_q` unchanged.
- R4: A selected write (code `2'b10`) of exactly 16 bits, LSB first, closed by an end command, shows the word on `reg_q` in the cycle after the end command.
- R5: A write closed by an end command after fewer than 16 bits leaves `reg_q` unchanged.
- R6: A write of more than 16 bits loads the last 16 bits received. The earliest of those 16 becomes bit 0.
- R7: A write cut short by any command other than end is discarded, and `reg_q` stays unchanged.
- R8: After a read command (code `2'b11`) while selected, the k-th prompt sets `sdo` to bit k-1 of `reg_q` in the next cycle. `sdo` holds that bit until the next prompt or command.
- R9: The 17th prompt of a read presents bit 0 again, and the word repeats every 16 prompts.
- R10: `sdo` is 0 outside a read phase and whenever the device is deselected. Prompts while deselected leave it at 0.
- R11: A data-bit or prompt strobe in the same cycle as a valid command is dropped, and the command takes effect alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command code is valid this cycle |
| cmd_code | input | 2 | 00 end, 01 address, 10 write, 11 read |
| bit_valid | input | 1 | One recovered data bit this cycle |
| bit_data | input | 1 | Value of that bit |
| prompt | input | 1 | Host asks for the next output bit |
| reg_q | output | 16 | Data register |
| sdo | output | 1 | Serial output bit, idle 0 |

## Verification
Two functions can meet in one cycle: a command that ends or changes the phase, and a bit or prompt strobe that would extend it. The bench provokes this in two ways. First, it asserts an end command together with the 16th write bit, so only 15 bits count and the register must not change. Second, it asserts a read command together with a prompt, so `sdo` must stay 0 and the next lone prompt must still present bit 0.

// File: rtl/srs_pkg.sv
package srs_pkg;
   typedef enum logic [1:0] {
      CMD_END   = 2'b00,
      CMD_ADDR  = 2'b01,
      CMD_WRITE = 2'b10,
      CMD_READ  = 2'b11
   } cmd_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_ADDR,
      PH_WRITE,
      PH_READ
   } phase_e;
endpackage

// File: rtl/srs_addr_match.sv
module srs_addr_match #(
   parameter int          ID_W   = 4,
   parameter logic [ID_W-1:0] DEV_ID = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic bit_en,
   input  logic bit_val,
   input  logic resolve,
   output logic sel
);
   localparam int CNT_W = $clog2(ID_W + 1);

   logic [ID_W-1:0]  sh_q;
   logic [CNT_W-1:0] cnt_q;
   logic [ID_W-1:0]  eq_bits;
   logic             full;

   initial assert (ID_W >= 2) else $fatal(1, "ID_W must be at least 2");

   // newest bit enters at the top; after ID_W bits the first one sits at bit 0
   always_ff @(posedge clk) begin
      if (rst || clr) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (bit_en) begin
         sh_q <= {bit_val, sh_q[ID_W-1:1]};
         if (cnt_q != CNT_W'(ID_W)) cnt_q <= cnt_q + 1'b1;
      end
   end

   for (genvar i = 0; i < ID_W; i++) begin : g_cmp
      assign eq_bits[i] = ~(sh_q[i] ^ DEV_ID[i]);
   end

   assign full = (cnt_q == CNT_W'(ID_W));

   always_ff @(posedge clk) begin
      if (rst)          sel <= 1'b0;
      else if (resolve) sel <= full && (&eq_bits);
   end

   p_addr_cnt_sat_r2: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(ID_W));
   p_addr_sel_needs_full_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(sel) |-> $past(cnt_q) == CNT_W'(ID_W));
endmodule

// File: rtl/srs_write_unit.sv
module srs_write_unit #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clr,
   input  logic              bit_en,
   input  logic              bit_val,
   input  logic              commit,
   output logic [DATA_W-1:0] data_q
);
   localparam int CNT_W = $clog2(DATA_W + 1);

   logic [DATA_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              enough;

   initial assert (DATA_W >= 2) else $fatal(1, "DATA_W must be at least 2");

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         sh_q  <= '0;
         cnt_q <= '0;
      end else if (bit_en) begin
         sh_q <= {bit_val, sh_q[DATA_W-1:1]};
         if (!enough) cnt_q <= cnt_q + 1'b1;
      end
   end

   assign enough = (cnt_q == CNT_W'(DATA_W));

   always_ff @(posedge clk) begin
      if (rst)                  data_q <= '0;
      else if (commit && enough) data_q <= sh_q;
   end

   p_wr_cnt_sat_r6: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CNT_W'(DATA_W));
   p_wr_commit_len_r5: assert property (@(posedge clk) disable iff (rst)
      !$stable(data_q) |-> $past(cnt_q) == CNT_W'(DATA_W));
endmodule

// File: rtl/srs_read_unit.sv
module srs_read_unit #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              stop,
   input  logic              prompt_en,
   input  logic [DATA_W-1:0] data,
   output logic              sdo
);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk) begin
      if (rst || stop) begin
         idx_q <= '0;
         sdo   <= 1'b0;
      end else if (prompt_en) begin
         sdo   <= data[idx_q];
         idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
      end
   end

   p_rd_idx_range_r9: assert property (@(posedge clk) disable iff (rst)
      idx_q <= LAST);
   p_rd_wrap_r9: assert property (@(posedge clk) disable iff (rst)
      ($past(prompt_en) && !$past(stop) && $past(idx_q) == LAST) |-> idx_q == '0);
endmodule

// File: rtl/addr_serial_slave.sv
module addr_serial_slave
   import srs_pkg::*;
#(
   parameter int              ID_W   = 4,
   parameter int              DATA_W = 16,
   parameter logic [ID_W-1:0] DEV_ID = 4'd5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_code,
   input  logic              bit_valid,
   input  logic              bit_data,
   input  logic              prompt,
   output logic [DATA_W-1:0] reg_q,
   output logic              sdo
);
   phase_e phase_q;
   cmd_e   cmd;
   logic   sel;
   logic   is_end, start_addr, start_wr;
   logic   bit_ok, prompt_ok;

   assign cmd        = cmd_e'(cmd_code);
   assign is_end     = cmd_valid && (cmd == CMD_END);
   assign start_addr = cmd_valid && (cmd == CMD_ADDR);
   assign start_wr   = cmd_valid && (cmd == CMD_WRITE);
   // a command owns its cycle: strobes arriving with it are dropped
   assign bit_ok     = bit_valid && !cmd_valid;
   assign prompt_ok  = prompt && !cmd_valid && sel && (phase_q == PH_READ);

   always_ff @(posedge clk) begin
      if (rst) phase_q <= PH_IDLE;
      else if (cmd_valid) begin
         unique case (cmd)
            CMD_ADDR:  phase_q <= PH_ADDR;
            CMD_WRITE: phase_q <= PH_WRITE;
            CMD_READ:  phase_q <= PH_READ;
            default:   phase_q <= PH_IDLE;
         endcase
      end
   end

   srs_addr_match #(.ID_W(ID_W), .DEV_ID(DEV_ID)) u_addr (
      .clk     (clk),
      .rst     (rst),
      .clr     (start_addr),
      .bit_en  (bit_ok && phase_q == PH_ADDR),
      .bit_val (bit_data),
      .resolve (is_end && phase_q == PH_ADDR),
      .sel     (sel)
   );

   srs_write_unit #(.DATA_W(DATA_W)) u_wr (
      .clk     (clk),
      .rst     (rst),
      .clr     (start_wr),
      .bit_en  (bit_ok && sel && phase_q == PH_WRITE),
      .bit_val (bit_data),
      .commit  (is_end && sel && phase_q == PH_WRITE),
      .data_q  (reg_q)
   );

   srs_read_unit #(.DATA_W(DATA_W)) u_rd (
      .clk       (clk),
      .rst       (rst),
      .stop      (cmd_valid),
      .prompt_en (prompt_ok),
      .data      (reg_q),
      .sdo       (sdo)
   );

   p_reset_clear_r1: assert property (@(posedge clk)
      $past(rst) |-> (reg_q == '0 && !sdo && !sel && phase_q == PH_IDLE));
   p_sel_source_r2: assert property (@(posedge clk) disable iff (rst)
      !$stable(sel) |-> $past(is_end && phase_q == PH_ADDR));
   p_commit_gate_r3: assert property (@(posedge clk) disable iff (rst)
      !$stable(reg_q) |-> $past(sel && is_end && phase_q == PH_WRITE));
   p_sdo_idle_r10: assert property (@(posedge clk) disable iff (rst)
      (phase_q != PH_READ || !sel) |-> !sdo);
   p_cmd_drops_prompt_r11: assert property (@(posedge clk) disable iff (rst)
      $past(cmd_valid) |-> !sdo);
endmodule

// File: tb/addr_serial_slave_test.sv
module addr_serial_slave_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_code = 2'b00;
   logic        bit_valid = 1'b0;
   logic        bit_data = 1'b0;
   logic        prompt = 1'b0;
   logic [15:0] reg_q;
   logic        sdo;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [1:0] C_END = 2'b00, C_ADDR = 2'b01, C_WR = 2'b10, C_RD = 2'b11;

   always #5 clk = ~clk;

   addr_serial_slave uut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .bit_valid(bit_valid), .bit_data(bit_data), .prompt(prompt),
      .reg_q(reg_q), .sdo(sdo)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // all drive tasks start and end on a falling edge
   task automatic cmd(input logic [1:0] c);
      cmd_valid = 1'b1; cmd_code = c;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic bits(input logic [31:0] v, input int n);
      for (int i = 0; i < n; i++) begin
         bit_valid = 1'b1; bit_data = v[i];
         @(negedge clk);
      end
      bit_valid = 1'b0;
   endtask

   task automatic pulse_prompt();
      prompt = 1'b1;
      @(negedge clk);
      prompt = 1'b0;
   endtask

   task automatic address(input logic [31:0] v, input int n);
      cmd(C_ADDR); bits(v, n); cmd(C_END);
   endtask

   task automatic write_word(input logic [31:0] v, input int n);
      cmd(C_WR); bits(v, n); cmd(C_END);
   endtask

   task automatic t_reset();
      check(reg_q == 16'h0, "R1 reg after reset", reg_q, 0);
      check(sdo == 1'b0, "R1 sdo after reset", sdo, 0);
   endtask

   task automatic t_deselected_write();
      write_word(32'hBEEF, 16);
      check(reg_q == 16'h0, "R3 write while deselected", reg_q, 0);
   endtask

   task automatic t_select_and_write();
      address(32'h5, 4);
      write_word(32'h1234, 16);
      check(reg_q == 16'h1234, "R2 R4 match then 16-bit write", reg_q, 16'h1234);
   endtask

   task automatic t_short_write();
      write_word(32'h7777, 15);
      check(reg_q == 16'h1234, "R5 15-bit write ignored", reg_q, 16'h1234);
   endtask

   task automatic t_long_write();
      write_word(32'hABCDE, 20);
      check(reg_q == 16'hABCD, "R6 last 16 of 20 bits", reg_q, 16'hABCD);
   endtask

   task automatic t_interrupted_write();
      cmd(C_WR); bits(32'h5555, 16); cmd(C_RD);
      check(reg_q == 16'hABCD, "R7 write cut by read", reg_q, 16'hABCD);
      cmd(C_END);
      check(reg_q == 16'hABCD, "R7 later end does not commit", reg_q, 16'hABCD);
   endtask

   task automatic t_read_wrap();
      int errs_before;
      cmd(C_RD);
      check(sdo == 1'b0, "R10 sdo idle before first prompt", sdo, 0);
      for (int k = 0; k < 20; k++) begin
         pulse_prompt();
         check(sdo == reg_q[k % 16], (k < 16) ? "R8 read bit" : "R9 wrapped read bit",
               sdo, reg_q[k % 16]);
      end
      @(negedge clk);
      check(sdo == reg_q[3], "R8 sdo holds between prompts", sdo, reg_q[3]);
      cmd(C_END);
      check(sdo == 1'b0, "R10 sdo idle after end", sdo, 0);
   endtask

   task automatic t_mismatch();
      address(32'h3, 4);
      write_word(32'hFFFF, 16);
      check(reg_q == 16'hABCD, "R2 mismatched id deselects", reg_q, 16'hABCD);
      cmd(C_RD);
      for (int k = 0; k < 4; k++) begin
         pulse_prompt();
         check(sdo == 1'b0, "R10 prompt while deselected", sdo, 0);
      end
      cmd(C_END);
   endtask

   task automatic t_short_and_long_address();
      address(32'h16, 6);               // last four bits 0101 -> id 5
      write_word(32'h0F0F, 16);
      check(reg_q == 16'h0F0F, "R2 over-long address keeps last 4", reg_q, 16'h0F0F);
      address(32'h5, 3);
      write_word(32'h1111, 16);
      check(reg_q == 16'h0F0F, "R2 3-bit address deselects", reg_q, 16'h0F0F);
   endtask

   task automatic t_collision();
      address(32'h5, 4);
      cmd(C_WR); bits(32'hC3C3, 15);
      bit_valid = 1'b1; bit_data = 1'b1; cmd_valid = 1'b1; cmd_code = C_END;
      @(negedge clk);
      bit_valid = 1'b0; cmd_valid = 1'b0;
      check(reg_q == 16'h0F0F, "R11 bit with end dropped", reg_q, 16'h0F0F);
      prompt = 1'b1; cmd_valid = 1'b1; cmd_code = C_RD;
      @(negedge clk);
      prompt = 1'b0; cmd_valid = 1'b0;
      check(sdo == 1'b0, "R11 prompt with read dropped", sdo, 0);
      pulse_prompt();
      check(sdo == reg_q[0], "R11 first lone prompt gives bit 0", sdo, reg_q[0]);
      pulse_prompt();
      check(sdo == reg_q[1], "R8 second prompt gives bit 1", sdo, reg_q[1]);
      cmd(C_END);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_deselected_write();
      t_select_and_write();
      t_short_write();
      t_long_write();
      t_interrupted_write();
      t_read_wrap();
      t_mismatch();
      t_short_and_long_address();
      t_collision();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule